// File: doc/BRIEF.md
# Scaled-Add Saturating Integer ALU

This block is the integer arithmetic lane of a wide-issue processor datapath. It receives two 64-bit register operands, a 16-bit immediate and a 5-bit operation code. It produces a 64-bit result and a flag that marks operation codes the lane does not execute.

The operations cover the following:
- wrapping full-width add and subtract;
- narrow 32-bit add and subtract, whose result takes the sign of bit 31 in its upper half;
- saturating 32-bit add and subtract;
- shift-then-add by 1, 2 or 3 bit positions;
- add of a sign-extended immediate;
- a shift-left-by-16 that merges the immediate into the vacated low bits.

The datapath is combinational. A parameter either places a register with synchronous reset on the outputs, or leaves the outputs combinational. The default is the registered form, with one cycle of latency.

In use, the issue stage presents an operation code with its operands. The writeback stage consumes the result on the following cycle. The writeback stage raises an illegal-instruction trap when the flag is set.

Top module: `sal_alu`

## Requirements
- R1: Code 0 returns `src_a + src_b` and code 3 returns `src_a - src_b`, both modulo 2^64 with no change to the upper half.
- R2: Codes 1 (add) and 4 (subtract) compute the 64-bit sum or difference. They then replace bits 63..32 with copies of bit 31 of that value, so a carry across bit 31 never reaches the upper half.
- R3: Codes 2 (add) and 5 (subtract) sign-extend bits 31..0 of each operand and ignore bits 63..32 of each operand. They combine the extended values, then clamp any value above 0x7FFFFFFF to 0x7FFFFFFF and any value below -0x80000000 to 0xFFFFFFFF80000000.
- R4: Codes 6/8/10 return `(src_a << k) + src_b` for k = 1/2/3. Codes 7/9/11 return the same sum with bits 63..32 replaced by copies of bit 31.
- R5: Code 12 returns `src_a` plus `imm` sign-extended from bit 15. Code 13 returns the same sum sign-extended from bit 31.
- R6: Code 14 returns `(src_a << 16) | imm`, with `imm` occupying bits 15..0.
- R7: Codes 15 to 31 set `unimpl` to 1 and drive `result` to zero.
- R8: With the output register fitted (the default), `result` and `unimpl` follow the inputs presented at the previous rising edge. A high `rst` sampled at an edge clears both outputs to zero.
- R9: Codes 0 to 14 leave `unimpl` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 5 | Operation code (see R1..R7) |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| imm | input | 16 | Immediate field |
| result | output | 64 | Operation result |
| unimpl | output | 1 | Operation code not executed by this lane |

## Verification
The assertions check the following properties on every cycle:
- the result is zero whenever the flag is set;
- the flag matches the code range;
- every narrow and saturating code leaves an upper half that copies bit 31;
- a saturating add of two non-negative low halves never yields a negative result;
- the insert form carries the immediate into the low 16 bits;
- a reset cycle clears the outputs.

Only the directed scenarios can show the exact values: the clamp at each bound, the disregard of nonzero upper operand halves by the saturating forms, the carries across bit 31, the shift amount of each scaled form, and the one-cycle latency.

// File: rtl/sal_pkg.sv
package sal_pkg;

    typedef enum logic [4:0] {
        OP_ADD     = 5'd0,
        OP_ADDW    = 5'd1,
        OP_ADDSAT  = 5'd2,
        OP_SUB     = 5'd3,
        OP_SUBW    = 5'd4,
        OP_SUBSAT  = 5'd5,
        OP_SH1ADD  = 5'd6,
        OP_SH1ADDW = 5'd7,
        OP_SH2ADD  = 5'd8,
        OP_SH2ADDW = 5'd9,
        OP_SH3ADD  = 5'd10,
        OP_SH3ADDW = 5'd11,
        OP_ADDIMM  = 5'd12,
        OP_ADDIMMW = 5'd13,
        OP_INS16   = 5'd14
    } op_e;

    localparam logic [4:0] FIRST_UNIMPL = 5'd15;

    typedef enum logic [1:0] {
        PATH_ARITH  = 2'd0,
        PATH_SAT    = 2'd1,
        PATH_INSERT = 2'd2,
        PATH_NONE   = 2'd3
    } path_e;

    typedef struct packed {
        path_e      path;
        logic [1:0] shamt;
        logic       negate;
        logic       use_imm;
        logic       narrow;
    } ctl_t;

endpackage

// File: rtl/sal_decode.sv
module sal_decode
    import sal_pkg::*;
(
    input  logic [4:0] op_sel,
    output ctl_t       ctl
);

    always_comb begin
        ctl = '{path: PATH_NONE, shamt: 2'd0, negate: 1'b0, use_imm: 1'b0, narrow: 1'b0};
        case (op_sel)
            OP_ADD:     ctl.path = PATH_ARITH;
            OP_ADDW:    begin ctl.path = PATH_ARITH; ctl.narrow = 1'b1; end
            OP_ADDSAT:  ctl.path = PATH_SAT;
            OP_SUB:     begin ctl.path = PATH_ARITH; ctl.negate = 1'b1; end
            OP_SUBW:    begin ctl.path = PATH_ARITH; ctl.negate = 1'b1; ctl.narrow = 1'b1; end
            OP_SUBSAT:  begin ctl.path = PATH_SAT; ctl.negate = 1'b1; end
            OP_SH1ADD:  begin ctl.path = PATH_ARITH; ctl.shamt = 2'd1; end
            OP_SH1ADDW: begin ctl.path = PATH_ARITH; ctl.shamt = 2'd1; ctl.narrow = 1'b1; end
            OP_SH2ADD:  begin ctl.path = PATH_ARITH; ctl.shamt = 2'd2; end
            OP_SH2ADDW: begin ctl.path = PATH_ARITH; ctl.shamt = 2'd2; ctl.narrow = 1'b1; end
            OP_SH3ADD:  begin ctl.path = PATH_ARITH; ctl.shamt = 2'd3; end
            OP_SH3ADDW: begin ctl.path = PATH_ARITH; ctl.shamt = 2'd3; ctl.narrow = 1'b1; end
            OP_ADDIMM:  begin ctl.path = PATH_ARITH; ctl.use_imm = 1'b1; end
            OP_ADDIMMW: begin ctl.path = PATH_ARITH; ctl.use_imm = 1'b1; ctl.narrow = 1'b1; end
            OP_INS16:   ctl.path = PATH_INSERT;
            default:    ctl.path = PATH_NONE;
        endcase
    end

endmodule

// File: rtl/sal_shift_adder.sv
module sal_shift_adder #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        shamt,
    input  logic              negate,
    output logic [DATA_W-1:0] sum
);

    logic [DATA_W-1:0] a_scaled;
    logic [DATA_W-1:0] b_term;

    always_comb begin
        a_scaled = opnd_a << shamt;
        b_term   = negate ? ~opnd_b : opnd_b;
        sum      = a_scaled + b_term + {{(DATA_W-1){1'b0}}, negate};
    end

endmodule

// File: rtl/sal_sat_clamp.sv
module sal_sat_clamp #(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              negate,
    output logic [DATA_W-1:0] clamped
);

    localparam int EXT_W = DATA_W - HALF_W;
    localparam logic [DATA_W-1:0] POS_LIMIT = {{(EXT_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIMIT = {{(EXT_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

    logic [DATA_W-1:0] a_wide;
    logic [DATA_W-1:0] b_wide;
    logic [DATA_W-1:0] raw;

    always_comb begin
        a_wide = {{EXT_W{opnd_a[HALF_W-1]}}, opnd_a[HALF_W-1:0]};
        b_wide = {{EXT_W{opnd_b[HALF_W-1]}}, opnd_b[HALF_W-1:0]};
        raw    = negate ? (a_wide - b_wide) : (a_wide + b_wide);
        if ($signed(raw) > $signed(POS_LIMIT)) begin
            clamped = POS_LIMIT;
        end else if ($signed(raw) < $signed(NEG_LIMIT)) begin
            clamped = NEG_LIMIT;
        end else begin
            clamped = raw;
        end
    end

endmodule

// File: rtl/sal_alu.sv
module sal_alu
    import sal_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int IMM_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              unimpl
);

    localparam int HALF_W = DATA_W / 2;

    ctl_t              ctl;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] addend;
    logic [DATA_W-1:0] arith_sum;
    logic [DATA_W-1:0] sat_out;
    logic [DATA_W-1:0] ins_out;
    logic [DATA_W-1:0] next_result;
    logic              next_unimpl;

    sal_decode u_decode (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    always_comb begin
        imm_wide = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        addend   = ctl.use_imm ? imm_wide : src_b;
        ins_out  = (src_a << IMM_W) | {{(DATA_W-IMM_W){1'b0}}, imm};
    end

    sal_shift_adder #(.DATA_W(DATA_W)) u_shift_adder (
        .opnd_a (src_a),
        .opnd_b (addend),
        .shamt  (ctl.shamt),
        .negate (ctl.negate),
        .sum    (arith_sum)
    );

    sal_sat_clamp #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_sat_clamp (
        .opnd_a  (src_a),
        .opnd_b  (src_b),
        .negate  (ctl.negate),
        .clamped (sat_out)
    );

    always_comb begin
        next_unimpl = 1'b0;
        unique case (ctl.path)
            PATH_ARITH: begin
                if (ctl.narrow) begin
                    next_result = {{HALF_W{arith_sum[HALF_W-1]}}, arith_sum[HALF_W-1:0]};
                end else begin
                    next_result = arith_sum;
                end
            end
            PATH_SAT:    next_result = sat_out;
            PATH_INSERT: next_result = ins_out;
            PATH_NONE: begin
                next_result = '0;
                next_unimpl = 1'b1;
            end
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg_out
            always_ff @(posedge clk) begin
                if (rst) begin
                    result <= '0;
                    unimpl <= 1'b0;
                end else begin
                    result <= next_result;
                    unimpl <= next_unimpl;
                end
            end
        end else begin : g_comb_out
            assign result = next_result;
            assign unimpl = next_unimpl;
        end
    endgenerate

endmodule

// File: rtl/sal_alu_chk.sv
module sal_alu_chk #(
    parameter int DATA_W  = 64,
    parameter int IMM_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        op_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm,
    input logic [DATA_W-1:0] result,
    input logic              unimpl
);

    localparam int HALF_W = DATA_W / 2;

    logic              seen_edge;
    logic              rst_obs;
    logic [4:0]        op_obs;
    logic [DATA_W-1:0] a_obs;
    logic [DATA_W-1:0] b_obs;
    logic [IMM_W-1:0]  imm_obs;
    logic              narrow_obs;

    always_ff @(posedge clk) seen_edge <= 1'b1;

    generate
        if (REG_OUT) begin : g_lag
            always_ff @(posedge clk) begin
                rst_obs <= rst;
                op_obs  <= op_sel;
                a_obs   <= src_a;
                b_obs   <= src_b;
                imm_obs <= imm;
            end
        end else begin : g_now
            assign rst_obs = 1'b0;
            assign op_obs  = op_sel;
            assign a_obs   = src_a;
            assign b_obs   = src_b;
            assign imm_obs = imm;
        end
    endgenerate

    always_comb begin
        narrow_obs = (op_obs == 5'd1) || (op_obs == 5'd2) || (op_obs == 5'd4) ||
                     (op_obs == 5'd5) || (op_obs == 5'd7) || (op_obs == 5'd9) ||
                     (op_obs == 5'd11) || (op_obs == 5'd13);
    end

    assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && unimpl) |-> (result == '0));

    assert_unimpl_code_R7: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !rst_obs && op_obs >= 5'd15) |-> unimpl);

    assert_impl_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && op_obs < 5'd15) |-> !unimpl);

    assert_upper_copies_R2: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !rst_obs && narrow_obs) |->
        (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}}));

    assert_sat_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !rst_obs && op_obs == 5'd2 && !a_obs[HALF_W-1] && !b_obs[HALF_W-1])
        |-> !result[DATA_W-1]);

    assert_insert_low_R6: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !rst_obs && op_obs == 5'd14) |-> (result[IMM_W-1:0] == imm_obs));

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && rst_obs) |-> (result == '0 && !unimpl));

endmodule

bind sal_alu sal_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_OUT(REG_OUT)) u_sal_alu_chk (
    .clk    (clk),
    .rst    (rst),
    .op_sel (op_sel),
    .src_a  (src_a),
    .src_b  (src_b),
    .imm    (imm),
    .result (result),
    .unimpl (unimpl)
);

// File: tb/test_sal_alu.sv
module test_sal_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  op_sel;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [15:0] imm;
    logic [63:0] result;
    logic        unimpl;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sal_alu i_sal_alu (
        .clk    (clk),
        .rst    (rst),
        .op_sel (op_sel),
        .src_a  (src_a),
        .src_b  (src_b),
        .imm    (imm),
        .result (result),
        .unimpl (unimpl)
    );

    function automatic logic [63:0] sx32(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    function automatic logic [63:0] clamp32(input logic [63:0] v);
        if ($signed(v) > 64'sh7FFF_FFFF) return 64'h0000_0000_7FFF_FFFF;
        if ($signed(v) < -64'sh8000_0000) return 64'hFFFF_FFFF_8000_0000;
        return v;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic got_u,
                         input logic [63:0] exp, input logic exp_u);
        n_checks++;
        if (got !== exp || got_u !== exp_u) begin
            n_fail++;
            $display("FAIL %s: result=%h unimpl=%b expected result=%h unimpl=%b",
                     tag, got, got_u, exp, exp_u);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] i);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; imm = i;
        @(posedge clk);
        #1;
    endtask

    task automatic run(input string tag, input logic [4:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [15:0] i, input logic [63:0] exp,
                       input logic exp_u);
        apply(op, a, b, i);
        check(tag, result, unimpl, exp, exp_u);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        apply(5'd0, 64'd5, 64'd6, 16'd0);
        check("R8 reset", result, unimpl, 64'd0, 1'b0);
        apply(5'd20, 64'd5, 64'd6, 16'd0);
        check("R8 reset holds unimpl low", result, unimpl, 64'd0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_full_addsub;
        run("R1 add wrap", 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 16'd0, 64'd1, 1'b0);
        run("R1 add carry b31", 5'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 16'd0,
            64'h0000_0001_0000_0000, 1'b0);
        run("R1 sub borrow", 5'd3, 64'd0, 64'd1, 16'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run("R9 sub flag", 5'd3, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_00F0, 16'd0,
            64'h1234_5678_9ABC_DE00, 1'b0);
    endtask

    task automatic t_narrow;
        logic [63:0] a = 64'h0000_0000_7FFF_FFFF;
        run("R2 addw carry into b31", 5'd1, a, 64'd1, 16'd0, sx32(a + 64'd1), 1'b0);
        run("R2 addw upper ignored", 5'd1, 64'hAAAA_0000_0000_0010, 64'h5555_0000_0000_0020,
            16'd0, 64'h0000_0000_0000_0030, 1'b0);
        run("R2 subw", 5'd4, 64'd0, 64'd1, 16'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run("R2 subw positive", 5'd4, 64'h0000_0001_0000_0005, 64'd3, 16'd0, 64'd2, 1'b0);
    endtask

    task automatic t_saturate;
        run("R3 add clamp high", 5'd2, 64'h0000_0000_7FFF_FFF0, 64'h0000_0000_0000_0100,
            16'd0, 64'h0000_0000_7FFF_FFFF, 1'b0);
        run("R3 add clamp low", 5'd2, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF,
            16'd0, 64'hFFFF_FFFF_8000_0000, 1'b0);
        run("R3 add upper halves ignored", 5'd2, 64'hDEAD_BEEF_0000_0003,
            64'h1234_5678_FFFF_FFFE, 16'd0, 64'd1, 1'b0);
        run("R3 sub clamp low", 5'd5, 64'h0000_0000_8000_0000, 64'd1, 16'd0,
            64'hFFFF_FFFF_8000_0000, 1'b0);
        run("R3 sub clamp high", 5'd5, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF,
            16'd0, 64'h0000_0000_7FFF_FFFF, 1'b0);
        run("R3 sub exact bound", 5'd5, 64'hFFFF_0000_FFFF_FFFF, 64'h0000_FFFF_7FFF_FFFF,
            16'd0, clamp32(sx32(64'hFFFF_FFFF) - sx32(64'h7FFF_FFFF)), 1'b0);
    endtask

    task automatic t_scaled;
        logic [63:0] a = 64'h4000_0000_4000_0001;
        logic [63:0] b = 64'h0000_0000_0000_0010;
        for (int k = 1; k <= 3; k++) begin
            logic [4:0] base = 5'(4 + 2 * k);
            run($sformatf("R4 shift %0d add", k), base, a, b, 16'd0, (a << k) + b, 1'b0);
            run($sformatf("R4 shift %0d add narrow", k), base + 5'd1, a, b, 16'd0,
                sx32((a << k) + b), 1'b0);
        end
    endtask

    task automatic t_addimm;
        run("R5 addimm negative", 5'd12, 64'h0000_0001_0000_0000, 64'hFFFF, 16'hFFFF,
            64'h0000_0000_FFFF_FFFF, 1'b0);
        run("R5 addimm narrow", 5'd13, 64'h0000_0001_0000_0000, 64'd0, 16'hFFFF,
            64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run("R5 addimm narrow carry", 5'd13, 64'h0000_0000_7FFF_FFFF, 64'd0, 16'h0001,
            64'hFFFF_FFFF_8000_0000, 1'b0);
    endtask

    task automatic t_insert;
        run("R6 insert", 5'd14, 64'hFFFF_1234_5678_9ABC, 64'd0, 16'hC0DE,
            64'h1234_5678_9ABC_C0DE, 1'b0);
    endtask

    task automatic t_unimpl;
        for (int c = 15; c < 32; c++) begin
            run($sformatf("R7 code %0d", c), 5'(c), 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 16'h1,
                64'd0, 1'b1);
        end
    endtask

    task automatic t_latency;
        run("R8 first value", 5'd0, 64'd10, 64'd20, 16'd0, 64'd30, 1'b0);
        @(negedge clk);
        op_sel = 5'd0; src_a = 64'd100; src_b = 64'd1;
        #1;
        check("R8 output waits for edge", result, unimpl, 64'd30, 1'b0);
        @(posedge clk);
        #1;
        check("R8 output after edge", result, unimpl, 64'd101, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 reset mid-run", result, unimpl, 64'd0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; op_sel = 5'd0; src_a = '0; src_b = '0; imm = '0;
        t_reset();
        t_full_addsub();
        t_narrow();
        t_saturate();
        t_scaled();
        t_addimm();
        t_insert();
        t_unimpl();
        t_latency();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule